// File: doc/BRIEF.md
# Field Regulator Wake and Sleep Controller

This block sequences a bus-controlled alternator field regulator through its power phases. It sleeps until the serial bus shows life or the machine shows a residual phase signal. Once awake, it keeps the field driver off until a valid message arrives. It then applies a fixed pre-excitation duty until the phase signal reaches the cut-in level, runs an internal soft-start ramp, and hands over to regulation.

Two timeouts, both clocked by a 1 ms tick, decide when it goes back to sleep. The bus timeout counts from the last valid message. The phase timeout counts how long the phase signal has stayed below its low thresholds without a break. In normal bus mode both must have expired. When the bus is faulted and residual phase signal is present, the block self-excites without any message. In that mode the phase timeout alone puts it back to sleep.

The analog comparators, the frame decoder and the PWM stage sit outside the block. Threshold crossings arrive as digital flags.

Top module: `regulator_wake_ctrl`

## Requirements
- R1: In sleep (`mode`=0), a received character equal to 0x80, or `bus_active` high, moves the block to awake (`mode`=1) on the next clock edge. Any other received character leaves it asleep.
- R2: While awake and waiting (`mode`=1), `field_en` is 0 and `duty_cmd` is 0. A `msg_valid` pulse moves the block to pre-excitation (`mode`=2) on the next edge.
- R3: In pre-excitation, `field_en` is 1 and `duty_cmd` holds 48 (18.75% of 256) for as long as `ph_cutin` stays low, whatever ticks pass.
- R4: `ph_cutin` high in pre-excitation starts the soft-start ramp (`mode`=3) with `ramp_req`=1. Each tick raises `duty_cmd` by RAMP_STEP. A tick that would reach or exceed 255 sets it to 255 and enters regulation (`mode`=4), where `ramp_req`=0 and `field_en`=1.
- R5: The bus timeout expires after BUS_TIMEOUT ticks with no `msg_valid`. Every `msg_valid` restarts it from zero.
- R6: The phase timeout expires after PHASE_TIMEOUT ticks during which `ph_low` stays high. Any cycle with `ph_low` low restarts it.
- R7: In bus mode the block returns to sleep one clock after the later of the two timeouts expires, never with only one expired. Sleep clears `field_en` and `duty_cmd`.
- R8: In sleep or awake, `bus_fault` and `ph_residual` both high start self-excitation: pre-excitation at duty 48 with no message. `ph_residual` without `bus_fault` does not.
- R9: In self-excited mode the phase timeout alone returns the block to sleep. A `msg_valid` returns it to bus mode, where both timeouts are again required.
- R10: Synchronous active-high `rst` forces sleep with `field_en`=0, `duty_cmd`=0 and `ramp_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| rx_strobe | input | 1 | Received-character strobe |
| rx_data | input | 8 | Received character |
| msg_valid | input | 1 | Valid-message strobe |
| bus_active | input | 1 | Normal bus activity seen |
| bus_fault | input | 1 | Bus is faulted |
| ph_cutin | input | 1 | Phase above cut-in voltage and speed |
| ph_residual | input | 1 | Phase above residual voltage and cut-in speed |
| ph_low | input | 1 | Phase below low voltage and low speed |
| field_en | output | 1 | Field driver enable |
| duty_cmd | output | 8 | Field duty command, n/256 |
| ramp_req | output | 1 | Soft-start ramp in progress |
| mode | output | 3 | Phase code: 0 sleep, 1 awake, 2 pre-excite, 3 ramp, 4 regulate |

## Verification
The bench sweeps all 256 character values from sleep. A decoder that matched too loosely would wake on a neighbour of 0x80, and one that ignored the character would never wake. It probes each timeout one tick short of its limit and at the limit, under both expiry orders. A block that slept on either timeout alone, or that missed a `ph_low` gap restarting the phase count, fails there. The ramp is followed tick by tick against an arithmetic model of the saturating step. Self-excitation is checked with and without the bus fault, and again after a message has returned control to the bus, where an early sleep would show up.

// File: rtl/regulator_wake_ctrl.sv
module regulator_wake_ctrl #(
  parameter int          BUS_TIMEOUT   = 2000,
  parameter int          PHASE_TIMEOUT = 500,
  parameter int          PRE_DUTY      = 48,
  parameter int          RAMP_STEP     = 8,
  parameter logic [7:0]  WAKE_CHAR     = 8'h80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_ms,
  input  logic       rx_strobe,
  input  logic [7:0] rx_data,
  input  logic       msg_valid,
  input  logic       bus_active,
  input  logic       bus_fault,
  input  logic       ph_cutin,
  input  logic       ph_residual,
  input  logic       ph_low,
  output logic       field_en,
  output logic [7:0] duty_cmd,
  output logic       ramp_req,
  output logic [2:0] mode
);

  localparam int BW = $clog2(BUS_TIMEOUT + 1);
  localparam int PW = $clog2(PHASE_TIMEOUT + 1);
  localparam logic [7:0] RAMP_TOP = 8'(255 - RAMP_STEP);

  typedef enum logic [2:0] {
    S_SLEEP = 3'd0, S_AWAKE = 3'd1, S_PRE = 3'd2, S_RAMP = 3'd3, S_REG = 3'd4
  } st_t;

  st_t           st;
  logic          self_exc;
  logic [BW-1:0] bus_cnt;
  logic [PW-1:0] ph_cnt;
  logic [7:0]    duty;

  wire bus_exp  = bus_cnt == BW'(BUS_TIMEOUT);
  wire ph_exp   = ph_cnt == PW'(PHASE_TIMEOUT);
  wire wake_hit = bus_active | (rx_strobe & (rx_data == WAKE_CHAR));
  wire self_hit = bus_fault & ph_residual;
  wire go_sleep = (st != S_SLEEP) & ph_exp & (bus_exp | self_exc);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_SLEEP;
      self_exc <= 1'b0;
      bus_cnt  <= '0;
      ph_cnt   <= '0;
      duty     <= '0;
    end else begin
      if (st == S_SLEEP) begin
        bus_cnt <= '0;
        ph_cnt  <= '0;
      end else begin
        if (msg_valid)               bus_cnt <= '0;
        else if (tick_ms && !bus_exp) bus_cnt <= bus_cnt + 1'b1;
        if (!ph_low)                 ph_cnt  <= '0;
        else if (tick_ms && !ph_exp)  ph_cnt  <= ph_cnt + 1'b1;
      end

      if (st == S_SLEEP) begin
        if (self_hit) begin
          st       <= S_PRE;
          self_exc <= 1'b1;
          duty     <= 8'(PRE_DUTY);
        end else if (wake_hit) begin
          st <= S_AWAKE;
        end
      end else if (go_sleep) begin
        st       <= S_SLEEP;
        self_exc <= 1'b0;
        duty     <= '0;
      end else begin
        if (msg_valid) self_exc <= 1'b0;
        case (st)
          S_AWAKE: begin
            if (msg_valid) begin
              st   <= S_PRE;
              duty <= 8'(PRE_DUTY);
            end else if (self_hit) begin
              st       <= S_PRE;
              self_exc <= 1'b1;
              duty     <= 8'(PRE_DUTY);
            end
          end
          S_PRE: if (ph_cutin) st <= S_RAMP;
          S_RAMP: begin
            if (tick_ms) begin
              if (duty >= RAMP_TOP) begin
                duty <= 8'hFF;
                st   <= S_REG;
              end else begin
                duty <= duty + 8'(RAMP_STEP);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign field_en = (st == S_PRE) | (st == S_RAMP) | (st == S_REG);
  assign duty_cmd = duty;
  assign ramp_req = st == S_RAMP;
  assign mode     = st;

  a_r1_stay_asleep: assert property (@(posedge clk) disable iff (rst)
    (st == S_SLEEP && !wake_hit && !self_hit) |=> st == S_SLEEP);

  a_r2_field_off_idle: assert property (@(posedge clk) disable iff (rst)
    (st == S_SLEEP || st == S_AWAKE) |-> (!field_en && duty_cmd == 8'd0));

  a_r3_pre_duty: assert property (@(posedge clk) disable iff (rst)
    st == S_PRE |-> duty_cmd == 8'(PRE_DUTY));

  a_r4_ramp_rises: assert property (@(posedge clk) disable iff (rst)
    (st == S_RAMP) |=> (duty_cmd >= $past(duty_cmd)));

  a_r7_no_early_sleep: assert property (@(posedge clk) disable iff (rst)
    (st != S_SLEEP && !ph_exp) |=> st != S_SLEEP);

  a_r9_self_sleep: assert property (@(posedge clk) disable iff (rst)
    (st != S_SLEEP && self_exc && ph_exp) |=> st == S_SLEEP);

endmodule

// File: tb/regulator_wake_ctrl_tb.sv
module regulator_wake_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_TO = 20;
  localparam int PH_TO  = 5;
  localparam int PRE    = 48;
  localparam int STEP   = 64;

  logic clk = 0, rst = 1, tick_ms = 0, rx_strobe = 0, msg_valid = 0;
  logic bus_active = 0, bus_fault = 0, ph_cutin = 0, ph_residual = 0, ph_low = 0;
  logic [7:0] rx_data = 0;
  logic field_en, ramp_req;
  logic [7:0] duty_cmd;
  logic [2:0] mode;
  int total = 0, bad = 0;

  regulator_wake_ctrl #(.BUS_TIMEOUT(BUS_TO), .PHASE_TIMEOUT(PH_TO), .PRE_DUTY(PRE),
    .RAMP_STEP(STEP), .WAKE_CHAR(8'h80)) u_dut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .rx_strobe(rx_strobe), .rx_data(rx_data),
    .msg_valid(msg_valid), .bus_active(bus_active), .bus_fault(bus_fault),
    .ph_cutin(ph_cutin), .ph_residual(ph_residual), .ph_low(ph_low),
    .field_en(field_en), .duty_cmd(duty_cmd), .ramp_req(ramp_req), .mode(mode));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(); @(posedge clk); @(negedge clk); endtask
  task automatic tick(int n); for (int i = 0; i < n; i++) begin tick_ms = 1; step(); tick_ms = 0; end endtask
  task automatic msg(); msg_valid = 1; step(); msg_valid = 0; endtask
  task automatic do_reset(); rst = 1; step(); rst = 0; endtask
  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin bad++; $display("FAIL %s act=%0d exp=%0d", req, act, exp); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); step(); rst = 0;
    // R10 reset state
    chk("R10 mode", mode, 0); chk("R10 field", field_en, 0);
    chk("R10 duty", duty_cmd, 0); chk("R10 ramp", ramp_req, 0);

    // R1 exhaustive character sweep
    for (int c = 0; c < 256; c++) begin
      do_reset();
      rx_data = 8'(c); rx_strobe = 1; step(); rx_strobe = 0;
      chk("R1 char wake", mode, (c == 8'h80) ? 1 : 0);
    end
    do_reset(); bus_active = 1; step(); bus_active = 0;
    chk("R1 bus activity", mode, 1);

    // R2 field off until message
    tick(3); chk("R2 awake field", field_en, 0); chk("R2 awake duty", duty_cmd, 0);
    msg(); chk("R2 msg mode", mode, 2); chk("R2 field on", field_en, 1);

    // R3 hold duty
    ph_residual = 1; tick(7);
    chk("R3 pre mode", mode, 2); chk("R3 pre duty", duty_cmd, PRE);
    ph_residual = 0;

    // R4 ramp
    ph_cutin = 1; step(); ph_cutin = 0;
    chk("R4 ramp mode", mode, 3); chk("R4 ramp req", ramp_req, 1); chk("R4 ramp start", duty_cmd, PRE);
    begin
      int e = PRE;
      while (e != 255) begin
        e = (e + STEP >= 255) ? 255 : e + STEP;
        tick(1);
        chk("R4 ramp duty", duty_cmd, e);
        chk("R4 ramp mode step", mode, (e == 255) ? 4 : 3);
      end
    end
    chk("R4 reg req", ramp_req, 0); chk("R4 reg field", field_en, 1);

    // R5 R6 R7: phase expires first, bus later
    msg(); ph_low = 1;
    tick(BUS_TO - 1); step();
    chk("R7 bus one short", mode, 4);
    tick(1); chk("R5 bus at limit still", mode, 4);
    step(); chk("R7 both expired", mode, 0);
    chk("R7 sleep field", field_en, 0); chk("R7 sleep duty", duty_cmd, 0);
    ph_low = 0;

    // bus expires first, phase later, with gap restart
    bus_active = 1; step(); bus_active = 0;
    tick(BUS_TO + 3); step(); chk("R7 bus only", mode, 1);
    ph_low = 1; tick(PH_TO - 1); ph_low = 0; step(); ph_low = 1;
    tick(PH_TO - 1); step(); chk("R6 gap restart", mode, 1);
    tick(1); step(); chk("R6 phase limit", mode, 0);
    ph_low = 0;

    // R5 message restarts bus count
    bus_active = 1; step(); bus_active = 0; ph_low = 1;
    tick(BUS_TO - 2); msg(); tick(BUS_TO - 1); step();
    chk("R5 restart", mode, 2);
    tick(1); step(); chk("R5 after restart", mode, 0);
    ph_low = 0;

    // R8 self-excitation
    ph_residual = 1; step(); chk("R8 no fault", mode, 0);
    bus_fault = 1; step(); bus_fault = 0; ph_residual = 0;
    chk("R8 self mode", mode, 2); chk("R8 self duty", duty_cmd, PRE); chk("R8 self field", field_en, 1);

    // R9 phase timeout alone
    ph_low = 1; tick(PH_TO); chk("R9 not yet", mode, 2);
    step(); chk("R9 self sleep", mode, 0);
    ph_low = 0;

    // R9 message returns to bus mode
    bus_fault = 1; ph_residual = 1; step(); bus_fault = 0; ph_residual = 0;
    msg(); ph_low = 1; tick(PH_TO + 2); step();
    chk("R9 bus mode needs both", mode, 2);
    tick(BUS_TO); step(); chk("R9 both now", mode, 0);
    ph_low = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule